// File: doc/BRIEF.md
# Rank-Aware Row-Hit Request Picker

This block picks the next request to serve from a queue of pending memory requests that all share one direction (every entry is a read, or every entry is a write). Each entry carries a valid bit, a rank, a bank within that rank and a row. The picker compares each entry's row with the currently open row of the bank it targets, using a per-bank table of open rows supplied from outside. Among the row hits, it favours the rank used by the previous burst, because staying on that rank avoids a bus turnaround bubble. When the command direction has just flipped, a gap exists anyway, so rank stops mattering and the oldest hit of any rank wins.

With no row hit in the queue, the picker falls back to the oldest entry whose bank is flagged in an earliest-bank mask from a separate mask generator. When nothing qualifies, it points at the queue head and drops its found flag. Selection is combinational over the whole queue and is captured into a registered index and found flag. Queue storage, timing checks and command issue are handled elsewhere.

Top module: `rank_hit_picker`

## Requirements
- R1: Entries are scanned from index 0 (oldest) upward, and an entry whose valid bit is 0 is never reported as found.
- R2: An entry is a row hit only when its bank is marked open and the open row equals the entry's row. The bank table index is rank*BANKS_PER_RANK + bank, so the same bank number on another rank never counts.
- R3: With dir_switch low, the oldest row hit whose rank equals last_rank is chosen ahead of every other entry.
- R4: With dir_switch high, rank is ignored, and the oldest row hit of any rank is chosen.
- R5: With dir_switch low and no row hit on last_rank, the oldest row hit on another rank is chosen.
- R6: A row hit on another rank is chosen even when an older non-hit entry has its bank set in early_mask.
- R7: With no row hit among valid entries, the oldest valid entry whose table bank bit is set in early_mask is chosen.
- R8: When no valid entry qualifies under R3 to R7, sel_found is 0 and sel_idx is 0.
- R9: sel_idx and sel_found show the choice for the inputs present at the previous rising clock edge. While rst_n is low, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_valid | input | DEPTH | Valid bit per queue entry, bit 0 oldest |
| q_rank | input | DEPTH*RANK_W | Rank of each entry, entry i at slice i |
| q_bank | input | DEPTH*BANK_W | Bank within rank of each entry |
| q_row | input | DEPTH*ROW_W | Row of each entry |
| bank_open | input | NBANK | Open-row flag per bank, index rank*BANKS_PER_RANK+bank |
| bank_row | input | NBANK*ROW_W | Open row per bank |
| last_rank | input | RANK_W | Rank of the previous burst |
| dir_switch | input | 1 | Command direction has just changed |
| early_mask | input | NBANK | Earliest-available bank mask |
| sel_idx | output | IDX_W | Registered index of the chosen entry |
| sel_found | output | 1 | Registered flag: a qualifying entry exists |

## Verification
A same-rank hit, a different-rank hit and a mask candidate can all be present in one cycle, and the priority between them is the main subject. Directed cases place these three kinds of entry at chosen ages: an older mask candidate in front of a different-rank hit, and a different-rank hit in front of a same-rank hit with dir_switch both low and high. A long run of constrained random queues then uses few ranks, banks and rows so that all three kinds often meet. Every cycle is judged against a behavioural model that walks the queue in age order.

// File: rtl/rank_hit_picker.sv
module rank_hit_picker #(
  parameter int DEPTH          = 16,
  parameter int RANKS          = 2,
  parameter int BANKS_PER_RANK = 8,
  parameter int ROW_W          = 14,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1,
  localparam int NBANK  = RANKS * BANKS_PER_RANK
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEPTH-1:0]          q_valid,
  input  logic [DEPTH*RANK_W-1:0]   q_rank,
  input  logic [DEPTH*BANK_W-1:0]   q_bank,
  input  logic [DEPTH*ROW_W-1:0]    q_row,
  input  logic [NBANK-1:0]          bank_open,
  input  logic [NBANK*ROW_W-1:0]    bank_row,
  input  logic [RANK_W-1:0]         last_rank,
  input  logic                      dir_switch,
  input  logic [NBANK-1:0]          early_mask,
  output logic [IDX_W-1:0]          sel_idx,
  output logic                      sel_found
);

  localparam int BID_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [DEPTH-1:0] prime, second, third;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [RANK_W-1:0] rk;
    logic [BANK_W-1:0] bk;
    logic [BID_W-1:0]  bid;
    logic              hit;
    assign rk    = q_rank[i*RANK_W +: RANK_W];
    assign bk    = q_bank[i*BANK_W +: BANK_W];
    assign bid   = BID_W'(rk) * BID_W'(BANKS_PER_RANK) + BID_W'(bk);
    assign hit   = q_valid[i] & bank_open[bid] &
                   (bank_row[bid*ROW_W +: ROW_W] == q_row[i*ROW_W +: ROW_W]);
    assign prime[i]  = hit & (dir_switch | (rk == last_rank));
    assign second[i] = hit & ~prime[i];
    assign third[i]  = q_valid[i] & ~hit & early_mask[bid];
  end

  function automatic logic [IDX_W-1:0] first_set(input logic [DEPTH-1:0] v);
    first_set = '0;
    for (int k = DEPTH - 1; k >= 0; k--)
      if (v[k]) first_set = IDX_W'(k);
  endfunction

  logic [IDX_W-1:0] nxt_idx;
  logic             nxt_found;

  assign nxt_found = |{prime, second, third};
  assign nxt_idx   = (|prime)  ? first_set(prime)  :
                     (|second) ? first_set(second) :
                     (|third)  ? first_set(third)  : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx   <= '0;
      sel_found <= 1'b0;
    end else begin
      sel_idx   <= nxt_idx;
      sel_found <= nxt_found;
    end
  end

endmodule

// File: rtl/rank_hit_picker_chk.sv
module rank_hit_picker_chk #(
  parameter int DEPTH          = 16,
  parameter int RANKS          = 2,
  parameter int BANKS_PER_RANK = 8,
  parameter int ROW_W          = 14,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1,
  localparam int NBANK  = RANKS * BANKS_PER_RANK
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [DEPTH-1:0]        q_valid,
  input logic [DEPTH*RANK_W-1:0] q_rank,
  input logic [DEPTH*BANK_W-1:0] q_bank,
  input logic [DEPTH*ROW_W-1:0]  q_row,
  input logic [NBANK-1:0]        bank_open,
  input logic [NBANK*ROW_W-1:0]  bank_row,
  input logic [RANK_W-1:0]       last_rank,
  input logic                    dir_switch,
  input logic [NBANK-1:0]        early_mask,
  input logic [IDX_W-1:0]        sel_idx,
  input logic                    sel_found
);

  int unsigned head_bid;
  logic        head_same;
  assign head_bid  = int'(q_rank[RANK_W-1:0]) * BANKS_PER_RANK + int'(q_bank[BANK_W-1:0]);
  assign head_same = q_valid[0] && (head_bid < NBANK) && bank_open[head_bid] &&
                     (bank_row[head_bid*ROW_W +: ROW_W] == q_row[ROW_W-1:0]) &&
                     (q_rank[RANK_W-1:0] == last_rank);

  logic [DEPTH-1:0] valid_d;
  logic             head_same_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_d     <= '0;
      head_same_d <= 1'b0;
    end else begin
      valid_d     <= q_valid;
      head_same_d <= head_same;
    end
  end

  assert_pick_is_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_found |-> valid_d[sel_idx]);

  assert_head_same_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    head_same_d |-> (sel_found && sel_idx == '0));

  assert_default_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_found |-> sel_idx == '0);

  assert_empty_queue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_d == '0) |-> !sel_found);

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |-> (!sel_found && sel_idx == '0));

endmodule

bind rank_hit_picker rank_hit_picker_chk #(
  .DEPTH(DEPTH), .RANKS(RANKS), .BANKS_PER_RANK(BANKS_PER_RANK), .ROW_W(ROW_W)
) u_chk (.*);

// File: tb/sim_rank_hit_picker.sv
module sim_rank_hit_picker;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16, RANKS = 2, BPR = 8, ROW_W = 14;
  localparam int IDX_W = 4, RANK_W = 1, BANK_W = 3, NBANK = RANKS * BPR;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DEPTH-1:0]        q_valid = '0;
  logic [DEPTH*RANK_W-1:0] q_rank = '0;
  logic [DEPTH*BANK_W-1:0] q_bank = '0;
  logic [DEPTH*ROW_W-1:0]  q_row = '0;
  logic [NBANK-1:0]        bank_open = '0;
  logic [NBANK*ROW_W-1:0]  bank_row = '0;
  logic [RANK_W-1:0]       last_rank = '0;
  logic                    dir_switch = 1'b0;
  logic [NBANK-1:0]        early_mask = '0;
  logic [IDX_W-1:0]        sel_idx;
  logic                    sel_found;

  rank_hit_picker #(.DEPTH(DEPTH), .RANKS(RANKS), .BANKS_PER_RANK(BPR), .ROW_W(ROW_W)) u0 (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_rank(q_rank), .q_bank(q_bank),
    .q_row(q_row), .bank_open(bank_open), .bank_row(bank_row), .last_rank(last_rank),
    .dir_switch(dir_switch), .early_mask(early_mask), .sel_idx(sel_idx), .sel_found(sel_found));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit ev[DEPTH]; int er[DEPTH], eb[DEPTH], ew[DEPTH];
  bit ov[NBANK]; int orow[NBANK]; bit em[NBANK];
  int lr = 0; bit sw = 0;
  int exp_idx = 0; bit exp_found = 0; string exp_tag = "R8";
  bit armed = 0;

  task automatic check(input string tag, input int idx, input bit fnd);
    n_chk++;
    if (int'(sel_idx) != idx || sel_found != fnd) begin
      n_fail++;
      $display("FAIL %s: idx=%0d found=%0d expected idx=%0d found=%0d",
               tag, sel_idx, sel_found, idx, fnd);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < DEPTH; i++) begin ev[i] = 0; er[i] = 0; eb[i] = 0; ew[i] = 0; end
    for (int b = 0; b < NBANK; b++) begin ov[b] = 0; orow[b] = 0; em[b] = 0; end
    lr = 0; sw = 0;
  endtask

  task automatic model();
    int s = -1, o = -1, e = -1;
    for (int i = 0; i < DEPTH; i++) begin
      int b; bit hit;
      if (!ev[i]) continue;
      b = er[i] * BPR + eb[i];
      hit = ov[b] && orow[b] == ew[i];
      if (hit) begin
        if (er[i] == lr || sw) begin if (s < 0) s = i; end
        else if (o < 0) o = i;
      end else if (em[b] && e < 0) e = i;
    end
    if (s >= 0)      begin exp_idx = s; exp_found = 1; exp_tag = sw ? "R4" : "R3"; end
    else if (o >= 0) begin exp_idx = o; exp_found = 1; exp_tag = (e >= 0 && e < o) ? "R6" : "R5"; end
    else if (e >= 0) begin exp_idx = e; exp_found = 1; exp_tag = "R7"; end
    else             begin exp_idx = 0; exp_found = 0; exp_tag = "R8"; end
  endtask

  // one cycle: check the previous choice (R9 timing), then drive the next queue
  task automatic step(input string extra);
    @(negedge clk);
    if (armed) check({exp_tag, extra}, exp_idx, exp_found);
    for (int i = 0; i < DEPTH; i++) begin
      q_valid[i] = ev[i];
      q_rank[i*RANK_W +: RANK_W] = RANK_W'(er[i]);
      q_bank[i*BANK_W +: BANK_W] = BANK_W'(eb[i]);
      q_row[i*ROW_W +: ROW_W]    = ROW_W'(ew[i]);
    end
    for (int b = 0; b < NBANK; b++) begin
      bank_open[b] = ov[b]; bank_row[b*ROW_W +: ROW_W] = ROW_W'(orow[b]); early_mask[b] = em[b];
    end
    last_rank = RANK_W'(lr); dir_switch = sw;
    model(); armed = 1;
  endtask

  task automatic put(input int i, input int r, input int b, input int w);
    ev[i] = 1; er[i] = r; eb[i] = b; ew[i] = w;
  endtask
  task automatic opn(input int r, input int b, input int w);
    ov[r*BPR+b] = 1; orow[r*BPR+b] = w;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", 0, 0);
    // inputs that would select entry 3 must not show during reset
    clr(); put(3, 0, 1, 7); opn(0, 1, 7);
    step(""); armed = 0;
    @(negedge clk); check("R9 held in reset", 0, 0);
    rst_n = 1'b1;
    step(" first cycle");
    // R8 empty queue
    clr(); step(" empty");
    // R8 valid entries, no hit, no mask
    clr(); put(0, 0, 2, 1); put(5, 1, 3, 4); step(" nothing qualifies");
    // R2 same bank number, other rank open with matching row: not a hit
    clr(); put(2, 1, 3, 5); opn(0, 3, 5); step(" R2 rank-indexed table");
    // R2 bank open, row mismatch; mask picks entry 4
    clr(); put(1, 0, 2, 9); opn(0, 2, 8); put(4, 1, 6, 0); em[1*BPR+6] = 1; step(" R2 row mismatch");
    // R3 same-rank hit newer than other-rank hit
    clr(); lr = 1; put(1, 0, 0, 3); opn(0, 0, 3); put(6, 1, 4, 2); opn(1, 4, 2); step(" R3");
    // R4 same queue while switching: oldest hit any rank
    sw = 1; step(" R4 switch");
    // R1 oldest among several same-rank hits
    clr(); put(3, 0, 1, 1); put(9, 0, 1, 1); opn(0, 1, 1); step(" R1 oldest");
    // R5 only other-rank hits
    clr(); lr = 0; put(7, 1, 2, 6); put(11, 1, 2, 6); opn(1, 2, 6); step(" R5");
    // R6 older mask candidate loses to other-rank hit
    clr(); put(0, 0, 5, 1); em[5] = 1; put(8, 1, 1, 2); opn(1, 1, 2); step(" R6");
    // R7 oldest masked entry among non-hits; invalid masked entry ignored (R1)
    clr(); put(2, 0, 3, 1); put(10, 1, 7, 1); em[1*BPR+7] = 1; em[3] = 0;
    er[0] = 0; eb[0] = 4; em[4] = 1; step(" R7 with invalid masked head");
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      clr();
      for (int i = 0; i < DEPTH; i++)
        if ($urandom % 3 != 0) put(i, $urandom % 2, $urandom % 4, $urandom % 3);
      for (int b = 0; b < NBANK; b++) begin
        ov[b] = ($urandom % 4 == 0); orow[b] = $urandom % 3; em[b] = ($urandom % 5 == 0);
      end
      lr = $urandom % 2; sw = ($urandom % 4 == 0);
      step(" random");
    end
    clr(); step(" drain");
    @(negedge clk); check({exp_tag, " final"}, exp_idx, exp_found);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule